// File: doc/BRIEF.md
# Keyed Two-Stage Watchdog

This block is a software-serviced watchdog. Software controls it through a single control register, which holds a 9-bit reload count, an enable bit and a 7-bit key. Once the watchdog is enabled, a write takes effect only if its key is the bitwise inverse of the key held from the last accepted write. Software must therefore alternate between a key and its complement each time it services the watchdog. A stray or runaway write is very unlikely to match.

An accepted write reloads the counter. The counter then counts down at a slow fixed tick, nominally 760 Hz, which a prescaler derives from the block clock. When the counter expires for the first time, the block raises a non-maskable interrupt and reloads a short grace count. If software does not service the watchdog before the grace count also runs out, the block raises a sticky system reset request. A status register reports the live count, whether the counter is running, and whether the block is in the interrupt stage.

Top module: `kwd_top`

## Requirements
- R1: After the synchronous reset, `nmi` and `reset_req` are 0, and both the control and status registers read as 0.
- R2: The control register sits at offset 0x40. Its bits [8:0] are the reload count, bit 8 is also the enable bit, and bits [15:9] are the key. A read returns the last accepted value. The status register sits at offset 0x44: bits [8:0] hold the live count, bit 9 is set while the counter runs, bit 10 is set in the interrupt stage, and all other bits are 0. Read data appears the cycle after `rd_en`.
- R3: While the stored enable bit is 0, every write to the control register is accepted, whatever key it carries, and the whole written value is stored.
- R4: While the stored enable bit is 1, a write whose key is not the bitwise inverse of the stored key is dropped. The stored value, the counter and `nmi` are left unchanged.
- R5: An accepted write clears `nmi` and the interrupt stage, and loads the counter from bits [8:0]. The counter runs if bit 8 is 1 and holds its value if bit 8 is 0. The write also restarts the prescaler.
- R6: Ticks occur every TICK_DIV = CLK_HZ/TICK_HZ cycles. The k-th tick falls on clock edge k*TICK_DIV after the accepted write, and each tick decrements a running counter by one.
- R7: When a tick finds a count of 1 or less, the first expiry occurs: `nmi` goes high, the count is reloaded with GRACE, and counting continues. For a loaded count N, `nmi` rises N*TICK_DIV edges after the write.
- R8: An expiry during the interrupt stage sets `reset_req` and stops the counter at 0. This happens (N+GRACE)*TICK_DIV edges after the write. `reset_req` stays set until the block is reset.
- R9: An accepted write during the interrupt stage prevents the reset request and starts a fresh countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write offset |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read offset |
| rd_data | output | 16 | Registered read data |
| nmi | output | 1 | Non-maskable interrupt, first expiry stage |
| reset_req | output | 1 | Sticky system reset request, second expiry stage |

## Verification
The state hardest to reach from the ports is the second expiry. Because bit 8 of the count doubles as the enable bit, every running count is at least 256. The reset request therefore arrives only after hundreds of ticks plus the grace period, with no write in between. The bench shrinks the prescaler to four cycles per tick and counts edges from the accepted write. It checks `nmi` and `reset_req` on the edge before and the edge after each predicted expiry. In a separate run it services the watchdog inside the grace window, after first sending a write with a wrong key that must not clear the interrupt. Key rejection is covered by sweeping all 128 keys against one stored key.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int COUNT_W = 9;
  localparam int KEY_W   = 7;
  localparam int EN_BIT  = 8;
  localparam int REG_W   = COUNT_W + KEY_W;

  function automatic logic [KEY_W-1:0] key_of(input logic [REG_W-1:0] v);
    return v[REG_W-1:COUNT_W];
  endfunction

  function automatic logic [COUNT_W-1:0] count_of(input logic [REG_W-1:0] v);
    return v[COUNT_W-1:0];
  endfunction
endpackage

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (pcnt == LAST) pcnt <= '0;
    else pcnt <= pcnt + W'(1);
  end

  assign tick = (pcnt == LAST);

  generate
    if (DIV > 1) begin : g_gap
      p_tick_gap_r6: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart) |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/kwd_keygate.sv
module kwd_keygate
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_ctrl,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic             accept
);
  logic             armed;
  logic [KEY_W-1:0] want_key;

  assign armed    = ctrl_q[EN_BIT];
  assign want_key = ~key_of(ctrl_q);
  assign accept   = wr_ctrl && (!armed || key_of(wr_data) == want_key);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (accept) ctrl_q <= wr_data;
  end

  p_reject_holds_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && ctrl_q[EN_BIT] && (wr_data[REG_W-1:COUNT_W] != ~ctrl_q[REG_W-1:COUNT_W]))
    |=> $stable(ctrl_q));

  p_disabled_accepts_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_ctrl && !ctrl_q[EN_BIT]) |=> (ctrl_q == $past(wr_data)));
endmodule

// File: rtl/kwd_stage.sv
module kwd_stage
  import kwd_pkg::*;
#(
  parameter int GRACE = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [COUNT_W-1:0] load_val,
  input  logic               tick,
  output logic [COUNT_W-1:0] cnt_q,
  output logic               run_q,
  output logic               nmi_q,
  output logic               rst_req_q
);
  localparam logic [COUNT_W-1:0] GRACE_V = COUNT_W'(GRACE);
  localparam logic [COUNT_W-1:0] ONE     = COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      run_q     <= 1'b0;
      nmi_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= load_val[EN_BIT];
      nmi_q <= 1'b0;
    end else if (run_q && tick) begin
      if (cnt_q <= ONE) begin
        if (!nmi_q) begin
          nmi_q <= 1'b1;
          cnt_q <= GRACE_V;
        end else begin
          rst_req_q <= 1'b1;
          run_q     <= 1'b0;
          cnt_q     <= '0;
        end
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  p_tick_decrement_r6: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

  p_stopped_holds_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !load) |=> $stable(cnt_q));

  p_load_clears_nmi_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !nmi_q);

  p_reset_after_nmi_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_q) |-> nmi_q);

  p_reset_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    rst_req_q |=> rst_req_q);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int              CLK_HZ   = 50_000_000,
  parameter int              TICK_HZ  = 760,
  parameter int              GRACE    = 10,
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = ADDR_W'(8'h40),
  parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8'h44)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  output logic              nmi,
  output logic              reset_req
);
  localparam int TICK_DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
  localparam int PAD_W    = REG_W - COUNT_W - 2;

  logic               wr_ctrl;
  logic               accept;
  logic               tick;
  logic [REG_W-1:0]   ctrl_q;
  logic [COUNT_W-1:0] cnt_q;
  logic               run_q;

  assign wr_ctrl = wr_en && (wr_addr == CTRL_OFS);

  kwd_keygate u_gate (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .accept  (accept)
  );

  kwd_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (accept),
    .tick    (tick)
  );

  kwd_stage #(.GRACE(GRACE)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_val  (count_of(wr_data)),
    .tick      (tick),
    .cnt_q     (cnt_q),
    .run_q     (run_q),
    .nmi_q     (nmi),
    .rst_req_q (reset_req)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) begin
      if (rd_addr == CTRL_OFS)      rd_data <= ctrl_q;
      else if (rd_addr == STAT_OFS) rd_data <= {{PAD_W{1'b0}}, nmi, run_q, cnt_q};
      else                          rd_data <= '0;
    end
  end

  p_nmi_needs_run_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(nmi) |-> $past(run_q));
endmodule

// File: tb/kwd_top_tb.sv
module kwd_top_tb_top;
  localparam int CLK_P = 10;
  localparam int DIV   = 4;
  localparam int GRACE = 10;
  localparam logic [7:0] A_CTRL = 8'h40;
  localparam logic [7:0] A_STAT = 8'h44;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        nmi;
  logic        reset_req;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int e0;

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  kwd_top #(.CLK_HZ(760*DIV), .TICK_HZ(760), .GRACE(GRACE)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .nmi(nmi), .reset_req(reset_req)
  );

  function automatic logic [15:0] mk(input int key, input int count);
    return 16'((key & 8'h7f) << 9) | 16'(count & 9'h1ff);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic to_edge(input int target);
    while (cyc < target) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v;
    logic [15:0] cur;
    do_reset();
    // R1: reset state
    chk("R1 nmi", int'(nmi), 0);
    chk("R1 reset_req", int'(reset_req), 0);
    rd(A_CTRL, v); chk("R1 ctrl", v, 0);
    rd(A_STAT, v); chk("R1 status", v, 0);

    // R3: disabled write with arbitrary key is stored whole
    wr(A_CTRL, mk(7'h55, 9'h0AB));
    rd(A_CTRL, v); chk("R3 R2 ctrl readback", v, int'(mk(7'h55, 9'h0AB)));
    rd(A_STAT, v); chk("R2 status stopped", v, 9'h0AB);
    repeat (20) @(posedge clk); #1;
    rd(A_STAT, v); chk("R5 stopped count holds", v, 9'h0AB);

    // enable: stored enable 0 so accepted; key 0x2A
    cur = mk(7'h2A, 276);
    wr(A_CTRL, cur); e0 = cyc;
    // R4: sweep every key except the complement 0x55
    for (int k = 0; k < 128; k++) begin
      if (k != 7'h55) begin
        wr(A_CTRL, mk(k, 9'h1FF));
        rd(A_CTRL, v); chk("R4 rejected key keeps ctrl", v, int'(cur));
      end
    end
    rd(A_STAT, v);
    chk("R4 R6 live count after sweep", v, (1 << 9) | (276 - (cyc - 1 - e0) / DIV));

    // R7/R8: timed first and second expiry, count 256 with key 0x55
    wr(A_CTRL, mk(7'h55, 256)); e0 = cyc;
    to_edge(e0 + 256*DIV - 1); chk("R7 nmi low before expiry", int'(nmi), 0);
    to_edge(e0 + 256*DIV);     chk("R7 nmi rises on expiry", int'(nmi), 1);
    rd(A_STAT, v); chk("R7 grace reload", v, (1 << 10) | (1 << 9) | GRACE);
    to_edge(e0 + (256+GRACE)*DIV - 1); chk("R8 reset_req low before grace end", int'(reset_req), 0);
    to_edge(e0 + (256+GRACE)*DIV);     chk("R8 reset_req rises", int'(reset_req), 1);
    rd(A_STAT, v); chk("R8 counter stopped", v, 1 << 10);
    repeat (50) @(posedge clk); #1;
    chk("R8 reset_req sticky", int'(reset_req), 1);

    // R9: service in the interrupt stage
    do_reset();
    wr(A_CTRL, mk(7'h11, 259)); e0 = cyc;
    to_edge(e0 + 259*DIV); chk("R7 nmi second run", int'(nmi), 1);
    wr(A_CTRL, mk(7'h11, 300));
    chk("R4 wrong key keeps nmi", int'(nmi), 1);
    wr(A_CTRL, mk(7'h6E, 300)); e0 = cyc;
    chk("R5 R9 service clears nmi", int'(nmi), 0);
    to_edge(e0 + 300*DIV - 1);
    chk("R9 no reset after service", int'(reset_req), 0);
    chk("R6 nmi low before new expiry", int'(nmi), 0);
    to_edge(e0 + 300*DIV); chk("R6 R7 nmi after reloaded count", int'(nmi), 1);

    // R5: stop with correct key
    wr(A_CTRL, mk(7'h11, 9'h0F0));
    chk("R5 stop write clears nmi", int'(nmi), 0);
    rd(A_STAT, v); chk("R5 stopped status", v, 9'h0F0);
    repeat (40) @(posedge clk); #1;
    rd(A_STAT, v); chk("R5 stopped count holds", v, 9'h0F0);
    chk("R5 nmi stays low", int'(nmi), 0);
    chk("R9 reset_req stays low", int'(reset_req), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule